// File: doc/BRIEF.md
# Byte-Serial Pixel Demultiplexer

This block turns an 8-bit byte stream, one byte per clock and qualified by a valid strobe, back into whole pixels with three parallel components. In chroma/luma mode the stream carries 4:2:2 samples in groups of four bytes. Each group holds two chroma bytes and two luma bytes, and it yields two pixels that share the group's two chroma values. In serial RGB mode the stream carries three bytes per pixel. A line-start input realigns the byte phase, so that a source can resynchronise at the start of every line.

Two configuration inputs shape the result. The order bit swaps which chroma sample comes first, or in RGB mode whether red or blue comes first. The reverse bit mirrors every output component from v to 255 - v. Components leave through registers. A one-cycle pulse on `out_valid` marks each new pixel, and the components hold their value between pulses.

The phase machine uses seven named states. For chroma/luma mode these are PH_CHROMA_A, PH_LUMA_A, PH_CHROMA_B and PH_LUMA_B. For RGB mode they are PH_RGB_FIRST, PH_RGB_MID and PH_RGB_LAST.

Its transitions work as follows:
- A valid byte advances the phase in a ring: CHROMA_A to LUMA_A to CHROMA_B to LUMA_B and back to CHROMA_A, or RGB_FIRST to RGB_MID to RGB_LAST and back to RGB_FIRST.
- Line-start forces the starting state of the selected mode.
- A family mismatch between the current state and the selected mode also forces the starting state of that mode.
- With no valid byte and no line-start, the state holds.

Top module: `ycd_byte_demux`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and all three components are 0.
- R2: With `mode_rgb`=0 and `order_swap`=0, a group of four valid bytes is taken as Cb, Y0, Cr, Y1. The third byte completes pixel A with out_c0=Y0, out_c1=Cb, out_c2=Cr. The fourth byte completes pixel B with out_c0=Y1 and the same Cb and Cr.
- R3: With `mode_rgb`=0 and `order_swap`=1, the group is taken as Cr, Y0, Cb, Y1. Pixel A and pixel B are formed as in R2, with out_c1 carrying Cb and out_c2 carrying Cr.
- R4: With `mode_rgb`=1 and `order_swap`=0, three valid bytes are taken as R, G, B. They give out_c0=R, out_c1=G and out_c2=B.
- R5: With `mode_rgb`=1 and `order_swap`=1, the three bytes are taken as B, G, R. The outputs are mapped as in R4.
- R6: When `reverse` is 1 in the cycle of the completing byte, every component of that pixel is output as 255 - v instead of v.
- R7: A cycle with `in_valid`=0 consumes no byte. It neither advances the phase nor emits a pixel.
- R8: A valid byte that arrives with `line_start`=1 is the first byte of a new group. A `line_start` pulse without a valid byte makes the next valid byte the first of a group.
- R9: `out_valid` pulses for exactly one cycle, on the cycle after the completing byte. The components keep their last value when no pixel is emitted.
- R10: If `mode_rgb` differs from the mode of the group in progress, the next valid byte starts a new group in the newly selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rgb | input | 1 | 1 = serial RGB triplets, 0 = 4:2:2 chroma/luma groups |
| order_swap | input | 1 | Swaps chroma order, or RGB/BGR order |
| reverse | input | 1 | Mirrors each output component to 255 - v |
| line_start | input | 1 | Realigns the byte phase to the start of a group |
| in_valid | input | 1 | Qualifies in_byte |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | One-cycle pulse per emitted pixel |
| out_c0 | output | 8 | Y, or R in RGB mode |
| out_c1 | output | 8 | Cb, or G in RGB mode |
| out_c2 | output | 8 | Cr, or B in RGB mode |

## Verification
A phase register that has slipped shows up at the ports on the next emitted pixel: luma turns up in a chroma field, or the pulse lands one byte early or late. This becomes visible within four valid bytes at most. A hold slot that is written at the wrong position corrupts pixel B of the group, or the RGB pixel, in the same cycle it is emitted. An inverted order or reverse decode corrupts every pixel at once. A bench model that tracks its own byte position therefore catches each of these faults within one group.

// File: rtl/ycd_pkg.sv
package ycd_pkg;

    typedef enum logic [2:0] {
        PH_CHROMA_A  = 3'd0,
        PH_LUMA_A    = 3'd1,
        PH_CHROMA_B  = 3'd2,
        PH_LUMA_B    = 3'd3,
        PH_RGB_FIRST = 3'd4,
        PH_RGB_MID   = 3'd5,
        PH_RGB_LAST  = 3'd6
    } phase_e;

    // Which byte of the group completes the pixel being emitted
    typedef enum logic [1:0] {
        EMIT_NONE        = 2'd0,
        EMIT_FROM_THIRD  = 2'd1,
        EMIT_FROM_FOURTH = 2'd2
    } emit_e;

    function automatic logic phase_is_rgb(input phase_e p);
        return (p == PH_RGB_FIRST) || (p == PH_RGB_MID) || (p == PH_RGB_LAST);
    endfunction

endpackage

// File: rtl/ycd_phase_fsm.sv
module ycd_phase_fsm
    import ycd_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_rgb,
    input  logic             line_start,
    input  logic             in_valid,
    output logic [NSLOT-1:0] slot_we,
    output emit_e            emit_kind
);

    phase_e phase_q;
    phase_e phase_d;
    phase_e eff_phase;
    phase_e start_phase;
    phase_e succ_phase;

    // Effective phase of the byte in this cycle
    always_comb begin
        start_phase = mode_rgb ? PH_RGB_FIRST : PH_CHROMA_A;
        if (line_start || (phase_is_rgb(phase_q) != mode_rgb)) begin
            eff_phase = start_phase;
        end else begin
            eff_phase = phase_q;
        end
    end

    // Transition ring
    always_comb begin
        unique case (eff_phase)
            PH_CHROMA_A:  succ_phase = PH_LUMA_A;
            PH_LUMA_A:    succ_phase = PH_CHROMA_B;
            PH_CHROMA_B:  succ_phase = PH_LUMA_B;
            PH_LUMA_B:    succ_phase = PH_CHROMA_A;
            PH_RGB_FIRST: succ_phase = PH_RGB_MID;
            PH_RGB_MID:   succ_phase = PH_RGB_LAST;
            PH_RGB_LAST:  succ_phase = PH_RGB_FIRST;
            default:      succ_phase = start_phase;
        endcase
        if (in_valid) begin
            phase_d = succ_phase;
        end else if (line_start) begin
            phase_d = start_phase;
        end else begin
            phase_d = phase_q;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CHROMA_A;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Per-state outputs
    always_comb begin
        slot_we   = '0;
        emit_kind = EMIT_NONE;
        if (in_valid) begin
            unique case (eff_phase)
                PH_CHROMA_A:  slot_we[0] = 1'b1;
                PH_LUMA_A:    slot_we[1] = 1'b1;
                PH_CHROMA_B: begin
                    slot_we[2] = 1'b1;
                    emit_kind  = EMIT_FROM_THIRD;
                end
                PH_LUMA_B:    emit_kind  = EMIT_FROM_FOURTH;
                PH_RGB_FIRST: slot_we[0] = 1'b1;
                PH_RGB_MID:   slot_we[1] = 1'b1;
                PH_RGB_LAST:  emit_kind  = EMIT_FROM_THIRD;
                default:      emit_kind  = EMIT_NONE;
            endcase
        end
    end

    AST_RESTART_YC: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && in_valid && !mode_rgb) |=> (phase_q == PH_LUMA_A)); // R8
    AST_RESTART_RGB: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && in_valid && mode_rgb) |=> (phase_q == PH_RGB_MID)); // R8
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !line_start) |=> $stable(phase_q)); // R7

endmodule

// File: rtl/ycd_hold_bank.sv
module ycd_hold_bank #(
    parameter int DW    = 8,
    parameter int NSLOT = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSLOT-1:0]          slot_we,
    input  logic [DW-1:0]             in_byte,
    output logic [NSLOT-1:0][DW-1:0]  hold
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold[i] <= '0;
            end else if (slot_we[i]) begin
                hold[i] <= in_byte;
            end
        end
    end

endmodule

// File: rtl/ycd_pixel_assemble.sv
module ycd_pixel_assemble
    import ycd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NSLOT = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_rgb,
    input  logic                      order_swap,
    input  logic                      reverse,
    input  emit_e                     emit_kind,
    input  logic [DW-1:0]             in_byte,
    input  logic [NSLOT-1:0][DW-1:0]  hold,
    output logic                      out_valid,
    output logic [2:0][DW-1:0]        out_pix
);

    localparam logic [DW-1:0] FULL = {DW{1'b1}};

    logic [DW-1:0]       first_c;
    logic [DW-1:0]       mid_c;
    logic [DW-1:0]       last_c;
    logic [2:0][DW-1:0]  comp;
    logic [2:0][DW-1:0]  comp_adj;
    logic                emit;

    always_comb begin
        emit    = (emit_kind != EMIT_NONE);
        first_c = hold[0];
        mid_c   = (emit_kind == EMIT_FROM_FOURTH) ? in_byte : hold[1];
        last_c  = (emit_kind == EMIT_FROM_FOURTH) ? hold[2] : in_byte;
        if (mode_rgb) begin
            comp[0] = order_swap ? last_c  : first_c;
            comp[1] = mid_c;
            comp[2] = order_swap ? first_c : last_c;
        end else begin
            comp[0] = mid_c;
            comp[1] = order_swap ? last_c  : first_c;
            comp[2] = order_swap ? first_c : last_c;
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_rev
        assign comp_adj[k] = reverse ? (FULL - comp[k]) : comp[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_pix <= comp_adj;
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_kind == EMIT_NONE) |=> $stable(out_pix)); // R9

endmodule

// File: rtl/ycd_byte_demux.sv
module ycd_byte_demux
    import ycd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_rgb,
    input  logic          order_swap,
    input  logic          reverse,
    input  logic          line_start,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    output logic          out_valid,
    output logic [DW-1:0] out_c0,
    output logic [DW-1:0] out_c1,
    output logic [DW-1:0] out_c2
);

    localparam int NSLOT = 3;

    logic [NSLOT-1:0]          slot_we;
    emit_e                     emit_kind;
    logic [NSLOT-1:0][DW-1:0]  hold;
    logic [2:0][DW-1:0]        out_pix;

    ycd_phase_fsm #(.NSLOT(NSLOT)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_rgb   (mode_rgb),
        .line_start (line_start),
        .in_valid   (in_valid),
        .slot_we    (slot_we),
        .emit_kind  (emit_kind)
    );

    ycd_hold_bank #(.DW(DW), .NSLOT(NSLOT)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_we (slot_we),
        .in_byte (in_byte),
        .hold    (hold)
    );

    ycd_pixel_assemble #(.DW(DW), .NSLOT(NSLOT)) asm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_rgb   (mode_rgb),
        .order_swap (order_swap),
        .reverse    (reverse),
        .emit_kind  (emit_kind),
        .in_byte    (in_byte),
        .hold       (hold),
        .out_valid  (out_valid),
        .out_pix    (out_pix)
    );

    assign out_c0 = out_pix[0];
    assign out_c1 = out_pix[1];
    assign out_c2 = out_pix[2];

    AST_OUT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R7
    AST_RGB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_rgb)) |=> !(out_valid && $past(mode_rgb))); // R4

endmodule

// File: tb/ycd_byte_demux_tb.sv
module ycd_byte_demux_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_rgb = 1'b0;
    logic       order_swap = 1'b0;
    logic       reverse = 1'b0;
    logic       line_start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_c0, out_c1, out_c2;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    int       m_pos = 0;
    bit       m_grp_rgb = 1'b0;
    logic [7:0] m_s0 = 8'h00, m_s1 = 8'h00, m_s2 = 8'h00;
    logic [7:0] e_c0 = 8'h00, e_c1 = 8'h00, e_c2 = 8'h00;

    always #5 clk = ~clk;

    ycd_byte_demux dut_i (
        .clk(clk), .rst_n(rst_n), .mode_rgb(mode_rgb), .order_swap(order_swap),
        .reverse(reverse), .line_start(line_start), .in_valid(in_valid),
        .in_byte(in_byte), .out_valid(out_valid),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    function automatic logic [7:0] mir(input bit rv, input logic [7:0] x);
        return rv ? (8'd255 - x) : x;
    endfunction

    task automatic step(input bit v, input bit ls, input bit m, input bit ord,
                        input bit rv, input logic [7:0] b, input string tag);
        bit exp_v = 1'b0;
        logic [7:0] y, cb, cr;
        in_valid = v; line_start = ls; mode_rgb = m;
        order_swap = ord; reverse = rv; in_byte = b;
        if (ls) begin m_pos = 0; m_grp_rgb = m; end
        if (v) begin
            if (m != m_grp_rgb) begin m_pos = 0; m_grp_rgb = m; end
            if (m) begin
                if (m_pos == 0) m_s0 = b;
                else if (m_pos == 1) m_s1 = b;
                else begin
                    exp_v = 1'b1;
                    e_c0 = mir(rv, ord ? b : m_s0);
                    e_c1 = mir(rv, m_s1);
                    e_c2 = mir(rv, ord ? m_s0 : b);
                end
                m_pos = (m_pos + 1) % 3;
            end else begin
                if (m_pos == 0) m_s0 = b;
                else if (m_pos == 1) m_s1 = b;
                else if (m_pos == 2) begin
                    m_s2 = b;
                    y = m_s1; cb = ord ? b : m_s0; cr = ord ? m_s0 : b;
                    exp_v = 1'b1;
                    e_c0 = mir(rv, y); e_c1 = mir(rv, cb); e_c2 = mir(rv, cr);
                end else begin
                    y = b; cb = ord ? m_s2 : m_s0; cr = ord ? m_s0 : m_s2;
                    exp_v = 1'b1;
                    e_c0 = mir(rv, y); e_c1 = mir(rv, cb); e_c2 = mir(rv, cr);
                end
                m_pos = (m_pos + 1) % 4;
            end
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== exp_v || out_c0 !== e_c0 || out_c1 !== e_c1 || out_c2 !== e_c2) begin
            failures++;
            $display("FAIL %s actual v=%0b %h %h %h expected v=%0b %h %h %h", tag,
                     out_valid, out_c0, out_c1, out_c2, exp_v, e_c0, e_c1, e_c2);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_c0 !== 8'h00 || out_c1 !== 8'h00 || out_c2 !== 8'h00) begin
            failures++;
            $display("FAIL R1 reset actual v=%0b %h %h %h expected 0 00 00 00",
                     out_valid, out_c0, out_c1, out_c2);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_c0 !== 8'h00) begin
            failures++;
            $display("FAIL R1 after reset actual v=%0b c0=%h expected 0 00", out_valid, out_c0);
        end
        // R2: Cb Y0 Cr Y1
        step(1, 1, 0, 0, 0, 8'h10, "R2");
        step(1, 0, 0, 0, 0, 8'h20, "R2");
        step(1, 0, 0, 0, 0, 8'h30, "R2");
        step(1, 0, 0, 0, 0, 8'h40, "R2");
        // R3: Cr Y0 Cb Y1
        step(1, 0, 0, 1, 0, 8'h51, "R3");
        step(1, 0, 0, 1, 0, 8'h62, "R3");
        step(1, 0, 0, 1, 0, 8'h73, "R3");
        step(1, 0, 0, 1, 0, 8'h84, "R3");
        // R4 and R5: RGB and BGR, line start aligns
        step(1, 1, 1, 0, 0, 8'hA1, "R4");
        step(1, 0, 1, 0, 0, 8'hB2, "R4");
        step(1, 0, 1, 0, 0, 8'hC3, "R4");
        step(1, 0, 1, 1, 0, 8'h0B, "R5");
        step(1, 0, 1, 1, 0, 8'h0C, "R5");
        step(1, 0, 1, 1, 0, 8'h0D, "R5");
        // R6: reverse on the completing byte
        step(1, 0, 1, 0, 0, 8'h00, "R6");
        step(1, 0, 1, 0, 0, 8'h7F, "R6");
        step(1, 0, 1, 0, 1, 8'hFF, "R6");
        // R7: gaps consume nothing
        step(1, 1, 0, 0, 0, 8'h11, "R7");
        step(0, 0, 0, 0, 0, 8'hEE, "R7");
        step(1, 0, 0, 0, 0, 8'h22, "R7");
        step(0, 0, 0, 0, 0, 8'hEE, "R7");
        step(0, 0, 0, 0, 0, 8'hDD, "R7");
        step(1, 0, 0, 0, 1, 8'h33, "R7");
        step(1, 0, 0, 0, 1, 8'h44, "R9");
        // R8: line start mid-group, and line start alone
        step(1, 0, 0, 0, 0, 8'h01, "R8");
        step(1, 0, 0, 0, 0, 8'h02, "R8");
        step(1, 1, 0, 0, 0, 8'h03, "R8");
        step(1, 0, 0, 0, 0, 8'h04, "R8");
        step(0, 1, 0, 0, 0, 8'h00, "R8");
        step(1, 0, 0, 0, 0, 8'h05, "R8");
        step(1, 0, 0, 0, 0, 8'h06, "R8");
        // R10: mode change without line start
        step(1, 0, 1, 0, 0, 8'h90, "R10");
        step(1, 0, 1, 0, 0, 8'h91, "R10");
        step(1, 0, 0, 0, 0, 8'h92, "R10");
        step(1, 0, 0, 0, 0, 8'h93, "R10");
        step(1, 0, 0, 0, 0, 8'h94, "R10");
        step(1, 0, 0, 0, 0, 8'h95, "R10");
        // Random mix
        void'($urandom(32'd2024));
        begin
            bit rm = 1'b0;
            for (int i = 0; i < 4000; i++) begin
                bit rv_v = ($urandom % 4) != 0;
                bit rv_ls = ($urandom % 25) == 0;
                bit rv_o = $urandom % 2;
                bit rv_r = $urandom % 2;
                if (($urandom % 60) == 0) rm = ~rm;
                step(rv_v, rv_ls, rm, rv_o, rv_r, 8'($urandom), rm ? "R4" : "R2");
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule